// File: doc/BRIEF.md
# Precomputed-Candidate Decision Feedback Loop

This block is the decision feedback section of a second-order (quadratic) nonlinear decision feedback equalizer for a binary on/off link. The feedback filter only ever sees binary decisions, so the product of two past decisions reduces to a logical AND. A linear term on one past decision is the same as the diagonal quadratic term, because a bit squared is the bit itself. The feedback filter output is therefore one of only 2^FB_ORDER values. The block computes all of them from the coefficient parameter when it is elaborated.

Each accepted feed-forward sample is added to every candidate feedback value in parallel, and every sum is sliced to one bit. These adders and slicers sit outside the recursion and can be pipelined with extra stages. The only recursive path is a 1-bit multiplexer. Its select is the register of the last FB_ORDER decisions, and the selected bit is the new decision, which is shifted into that register. Valid samples may arrive every cycle or with gaps, and one decision comes out for each valid sample.

Top module: `dfl_loop`

## Requirements
- R1: While reset is asserted and right after it, `decValid` and `decision` are 0 and the decision history is all zeros, so the first decision after reset uses a feedback value of 0.
- R2: A decision is 1 when the full-precision sum of the signed 14-bit feed-forward sample and the feedback value is greater than or equal to zero, and 0 otherwise.
- R3: The feedback value for a decision is the sum of coefficient (i,j) over every pair with i <= j where both the decision from i+1 samples back and the decision from j+1 samples back are 1. The diagonal entries (i,i) act as the linear terms.
- R4: Coefficient (i,j) occupies bits [(i*FB_ORDER+j)*WIDTH +: WIDTH] of `COEFS` as a signed value. Entries with i > j have no effect on any decision.
- R5: The decision history advances only on a valid sample. Samples presented while `ffValid` is low have no effect on later decisions.
- R6: Every sample accepted at a clock edge produces exactly one `decValid` pulse, 2+EXTRA_STAGES edges later, in input order.
- R7: Between valid pulses, `decision` holds the most recent decision.
- R8: The loop works for FB_ORDER of 3 and of 4, with WIDTH 14.
- R9: Valid samples on every consecutive cycle are sustained, with one decision per cycle.
- R10: Full-scale samples (-8192 and 8191) and sums of exactly zero are sliced correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ffValid | input | 1 | Feed-forward sample valid |
| ffSample | input | WIDTH | Signed feed-forward filter output |
| decValid | output | 1 | Decision valid strobe |
| decision | output | 1 | Equalized binary decision |

## Verification
The bench aims at the history patterns where the cross terms switch on and off. A design that mapped history bits to the wrong lag, or dropped an AND term, would slice samples near zero to the wrong bit. It feeds sums that land exactly on zero and full-scale samples, which catch a strict-greater slicer or a truncated sum width. The lower-triangle coefficients are filled with large values, so a design that read them would flip decisions. Gaps with random sample values on the input would disturb the history if it advanced on invalid cycles. A reset in the middle of the run shows whether the history really returns to zero.

// File: rtl/dfl_pkg.sv
package dfl_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic ldIn;    // capture the feed-forward sample
    logic ldCand;  // capture the sliced candidate bits
    logic step;    // advance the decision loop
  } dflStrobe_t;

  // Number of quadratic terms in an upper-triangular kernel of a given order.
  function automatic int triTerms(input int order);
    return order * (order + 1) / 2;
  endfunction

endpackage

// File: rtl/dfl_control.sv
module dfl_control
  import dfl_pkg::*;
#(
  parameter int EXTRA_STAGES = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ffValid,
  output dflStrobe_t strobes,
  output logic       decValid
);

  localparam int PIPE_DEPTH = EXTRA_STAGES + 3;

  logic vIn;
  logic vCand;
  logic tailValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      vIn   <= 1'b0;
      vCand <= 1'b0;
    end else begin
      vIn   <= ffValid;
      vCand <= vIn;
    end
  end

  generate
    if (EXTRA_STAGES == 0) begin : g_noDelay
      assign tailValid = vCand;
    end else begin : g_delay
      logic [EXTRA_STAGES-1:0] vDly;
      always_ff @(posedge clk) begin
        if (rst) begin
          vDly <= '0;
        end else begin
          vDly[0] <= vCand;
          for (int k = 1; k < EXTRA_STAGES; k++) vDly[k] <= vDly[k-1];
        end
      end
      assign tailValid = vDly[EXTRA_STAGES-1];
    end
  endgenerate

  always_comb begin
    strobes.ldIn   = ffValid;
    strobes.ldCand = vIn;
    strobes.step   = tailValid;
  end

  always_ff @(posedge clk) begin
    if (rst) decValid <= 1'b0;
    else     decValid <= tailValid;
  end

  // Checker state: samples accepted and not yet retired at the output.
  logic [7:0] inFlight;
  always_ff @(posedge clk) begin
    if (rst) inFlight <= '0;
    else     inFlight <= inFlight + 8'(ffValid) - 8'(decValid);
  end

  // R6: no output without a pending input.
  p_no_spurious_r6: assert property (@(posedge clk) disable iff (rst)
    decValid |-> (inFlight != 8'd0));

  // R6: the pipeline never holds more samples than its depth.
  p_inflight_bound_r6: assert property (@(posedge clk) disable iff (rst)
    inFlight <= 8'(PIPE_DEPTH));

endmodule

// File: rtl/dfl_datapath.sv
module dfl_datapath
  import dfl_pkg::*;
#(
  parameter int FB_ORDER     = 3,
  parameter int WIDTH        = 14,
  parameter int EXTRA_STAGES = 0,
  parameter logic [FB_ORDER*FB_ORDER*WIDTH-1:0] COEFS = '0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  dflStrobe_t              strobes,
  input  logic signed [WIDTH-1:0] ffSample,
  output logic                    decision
);

  localparam int NCAND = 1 << FB_ORDER;
  localparam int TERMS = triTerms(FB_ORDER);
  localparam int SUMW  = WIDTH + $clog2(TERMS + 2) + 1;

  typedef logic signed [SUMW-1:0] sum_t;

  // Feedback value for one history pattern; bit k of the pattern is the
  // decision k+1 samples back.
  function automatic sum_t candValue(input int pattern);
    sum_t acc;
    logic signed [WIDTH-1:0] c;
    acc = '0;
    for (int i = 0; i < FB_ORDER; i++) begin
      for (int j = i; j < FB_ORDER; j++) begin
        if ((((pattern >> i) & 1) != 0) && (((pattern >> j) & 1) != 0)) begin
          c   = COEFS[(i*FB_ORDER+j)*WIDTH +: WIDTH];
          acc = acc + sum_t'(c);
        end
      end
    end
    return acc;
  endfunction

  // Input capture.
  logic signed [WIDTH-1:0] ffReg;
  always_ff @(posedge clk) begin
    if (rst)               ffReg <= '0;
    else if (strobes.ldIn) ffReg <= ffSample;
  end

  // Candidate adders and slicers, one per history pattern.
  logic [NCAND-1:0] sliceBits;
  generate
    for (genvar p = 0; p < NCAND; p++) begin : g_cand
      localparam sum_t CAND = candValue(p);
      sum_t candSum;
      assign candSum      = sum_t'(ffReg) + CAND;
      assign sliceBits[p] = ~candSum[SUMW-1];
    end
  endgenerate

  logic [NCAND-1:0] candReg;
  always_ff @(posedge clk) begin
    if (rst)                 candReg <= '0;
    else if (strobes.ldCand) candReg <= sliceBits;
  end

  // Optional retiming stages between slicers and loop.
  logic [NCAND-1:0] tailBits;
  generate
    if (EXTRA_STAGES == 0) begin : g_noDelay
      assign tailBits = candReg;
    end else begin : g_delay
      logic [EXTRA_STAGES-1:0][NCAND-1:0] dlyQ;
      always_ff @(posedge clk) begin
        if (rst) begin
          dlyQ <= '0;
        end else begin
          dlyQ[0] <= candReg;
          for (int k = 1; k < EXTRA_STAGES; k++) dlyQ[k] <= dlyQ[k-1];
        end
      end
      assign tailBits = dlyQ[EXTRA_STAGES-1];
    end
  endgenerate

  // Recursive loop: one multiplexer and the history register.
  logic [FB_ORDER-1:0] hist;
  logic                decBit;
  assign decBit = tailBits[hist];

  always_ff @(posedge clk) begin
    if (rst) begin
      hist     <= '0;
      decision <= 1'b0;
    end else if (strobes.step) begin
      hist     <= {hist[FB_ORDER-2:0], decBit};
      decision <= decBit;
    end
  end

  // R2: the all-zero pattern has no feedback, so its bit is the sample sign.
  p_zero_pattern_r2: assert property (@(posedge clk) disable iff (rst)
    strobes.ldCand |=> (candReg[0] == !$past(ffReg[WIDTH-1])));

  // R5: history only moves on a loop step.
  p_hist_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !strobes.step |=> $stable(hist));

  // R7: decision holds between steps.
  p_dec_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !strobes.step |=> $stable(decision));

endmodule

// File: rtl/dfl_loop.sv
module dfl_loop
  import dfl_pkg::*;
#(
  parameter int FB_ORDER     = 3,
  parameter int WIDTH        = 14,
  parameter int EXTRA_STAGES = 0,
  parameter logic [FB_ORDER*FB_ORDER*WIDTH-1:0] COEFS = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ffValid,
  input  logic [WIDTH-1:0] ffSample,
  output logic             decValid,
  output logic             decision
);

  dflStrobe_t strobes;

  dfl_control #(
    .EXTRA_STAGES(EXTRA_STAGES)
  ) u_control (
    .clk     (clk),
    .rst     (rst),
    .ffValid (ffValid),
    .strobes (strobes),
    .decValid(decValid)
  );

  dfl_datapath #(
    .FB_ORDER    (FB_ORDER),
    .WIDTH       (WIDTH),
    .EXTRA_STAGES(EXTRA_STAGES),
    .COEFS       (COEFS)
  ) u_datapath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .ffSample($signed(ffSample)),
    .decision(decision)
  );

endmodule

// File: tb/dfl_loop_bench.sv
module dfl_loop_bench;

  localparam int W    = 14;
  localparam int MA   = 3;
  localparam int MB   = 4;
  localparam int EA   = 0;
  localparam int EB   = 1;
  localparam int LATA = 2 + EA;
  localparam int LATB = 2 + EB;

  // Kernel for order 3; lower-triangle entries are large decoys (R4).
  function automatic int coefA(input int i, input int j);
    case (i*MA + j)
      0: return 1000;   1: return -2500;  2: return 700;
      4: return -600;   5: return -400;   8: return 300;
      3: return 5000;   6: return -5000;  7: return 4000;
      default: return 0;
    endcase
  endfunction

  // Kernel for order 4 (R8); lower triangle filled with decoys.
  function automatic int coefB(input int i, input int j);
    case (i*MB + j)
      0: return 900;    1: return -1800;  2: return 500;   3: return -300;
      5: return -700;   6: return 1200;   7: return -900;
      10: return 400;   11: return -1500; 15: return -200;
      default: return 3333;
    endcase
  endfunction

  function automatic logic [MA*MA*W-1:0] packA();
    logic [MA*MA*W-1:0] v;
    for (int k = 0; k < MA*MA; k++) v[k*W +: W] = W'(coefA(k / MA, k % MA));
    return v;
  endfunction

  function automatic logic [MB*MB*W-1:0] packB();
    logic [MB*MB*W-1:0] v;
    for (int k = 0; k < MB*MB; k++) v[k*W +: W] = W'(coefB(k / MB, k % MB));
    return v;
  endfunction

  localparam logic [MA*MA*W-1:0] COEF_A = packA();
  localparam logic [MB*MB*W-1:0] COEF_B = packB();

  logic clk = 1'b0;
  logic rst;
  logic ffValid;
  logic [W-1:0] ffSample;
  logic decValidA, decA, decValidB, decB;

  always #2 clk = ~clk;

  dfl_loop #(.FB_ORDER(MA), .WIDTH(W), .EXTRA_STAGES(EA), .COEFS(COEF_A)) u_dfl_loop (
    .clk(clk), .rst(rst), .ffValid(ffValid), .ffSample(ffSample),
    .decValid(decValidA), .decision(decA));

  dfl_loop #(.FB_ORDER(MB), .WIDTH(W), .EXTRA_STAGES(EB), .COEFS(COEF_B)) u_dfl_loop_wide (
    .clk(clk), .rst(rst), .ffValid(ffValid), .ffSample(ffSample),
    .decValid(decValidB), .decision(decB));

  int nChecks = 0;
  int nFail   = 0;
  int cyc     = 0;
  int histA   = 0;
  int histB   = 0;
  bit lastA   = 1'b0;
  bit lastB   = 1'b0;
  bit qA[$];
  bit qB[$];
  int tA[$];
  int tB[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Behavioural feedback model (R3): AND of two past decisions per term.
  function automatic int feedback(input int hist, input int order, input bit wide);
    int acc = 0;
    for (int i = 0; i < order; i++)
      for (int j = i; j < order; j++)
        if (((hist >> i) & 1) != 0 && ((hist >> j) & 1) != 0)
          acc += wide ? coefB(i, j) : coefA(i, j);
    return acc;
  endfunction

  task automatic push(input bit v, input int s);
    bit d;
    @(negedge clk);
    #1;
    ffValid  = v;
    ffSample = W'(s);
    if (v) begin
      d = (s + feedback(histA, MA, 1'b0)) >= 0;   // R2 slicer rule
      qA.push_back(d); tA.push_back(cyc + 1);
      histA = ((histA << 1) | int'(d)) & ((1 << MA) - 1);
      d = (s + feedback(histB, MB, 1'b1)) >= 0;
      qB.push_back(d); tB.push_back(cyc + 1);
      histB = ((histB << 1) | int'(d)) & ((1 << MB) - 1);
    end
  endtask

  task automatic doReset(input int n);
    @(negedge clk);
    #1;
    rst = 1'b1; ffValid = 1'b0;
    repeat (n) @(negedge clk);
    #1;
    rst = 1'b0;
    histA = 0; histB = 0; lastA = 1'b0; lastB = 1'b0;
  endtask

  // Output comparison away from the active edge.
  always @(negedge clk) begin
    bit e;
    int st;
    if (rst === 1'b1) begin
      // R1: outputs cleared during reset
      chk(decValidA == 1'b0 && decA == 1'b0, "R1 reset outputs order3", {decValidA, decA}, 0);
      chk(decValidB == 1'b0 && decB == 1'b0, "R1 reset outputs order4", {decValidB, decB}, 0);
    end else if (rst === 1'b0) begin
      if (decValidA) begin
        if (qA.size() == 0) chk(1'b0, "R6 unexpected output order3", 1, 0);
        else begin
          e = qA.pop_front(); st = tA.pop_front();
          chk(decA == e, "R2 R3 R4 R5 R8 decision order3", decA, e);
          chk(cyc == st + LATA, "R6 latency order3", cyc - st, LATA);
          lastA = decA;
        end
      end else chk(decA == lastA, "R7 hold order3", decA, lastA);
      if (decValidB) begin
        if (qB.size() == 0) chk(1'b0, "R6 unexpected output order4", 1, 0);
        else begin
          e = qB.pop_front(); st = tB.pop_front();
          chk(decB == e, "R2 R3 R4 R5 R8 decision order4", decB, e);
          chk(cyc == st + LATB, "R6 latency order4", cyc - st, LATB);
          lastB = decB;
        end
      end else chk(decB == lastB, "R7 hold order4", decB, lastB);
    end
  end

  initial begin
    rst = 1'b1; ffValid = 1'b0; ffSample = '0;
    repeat (4) @(negedge clk);
    #1 rst = 1'b0;
    // R1: first decisions see an all-zero history; R10 zero sum slices to 1
    push(1, -1);
    push(1, 0);
    push(1, -1000);
    // R9: consecutive valid cycles; R10: full-scale values
    push(1, 8191);
    push(1, -8192);
    push(1, 2500);
    push(1, 0);
    push(0, 7777);   // R5: ignored sample
    push(1, -700);
    for (int n = 0; n < 900; n++) begin
      int r, s;
      r = $urandom_range(15);
      if (r == 0)      s = 8191;
      else if (r == 1) s = -8192;
      else if (r == 2) s = 0;
      else             s = int'($urandom_range(6000)) - 3000;
      push($urandom_range(3) != 0, s);
    end
    repeat (10) push(0, -4000);
    // R1: reset mid-run clears the history
    doReset(3);
    push(1, -1);
    push(1, 0);
    push(1, -1);
    for (int n = 0; n < 200; n++) push(1'b1, int'($urandom_range(4000)) - 2000);
    repeat (10) push(0, 0);
    chk(qA.size() == 0 && qB.size() == 0, "R6 all outputs delivered", qA.size() + qB.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired R6", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule